// File: doc/BRIEF.md
# General-Purpose Flag Bank with Interrupt Request

This block manages a bank of bidirectional general-purpose pins, `NPINS` wide (16 by default). Each pin has a direction bit. The block drives the output value and output enable of each pin and samples each pin's input through a two-flop synchroniser. Software changes output values and interrupt enables through paired write-one-to-set and write-one-to-clear addresses. A single write can therefore raise or drop any group of flags without touching the others, and no read-modify-write is needed.

Each pin can request an interrupt. The request comes from the synchronised pin when the pin is an input, or from the software-driven value when it is an output. Per pin, the request is either level-sensitive or edge-sensitive. An edge-sensitive pin responds to the rising edge only or to both edges. Edge events are held in a per-pin latch. Writing a one to the pin's bit at the clear address discards the latched event. The masked requests are ORed together, and the result is registered onto one interrupt line.

The register port is a simple synchronous bus. A write takes effect at the clock edge where it is presented. Read data is registered and is valid one cycle after the read is presented.

Top module: `gpio_flag_bank`

## Requirements
- R1: After reset, direction, output, mask, edge-select and both-edge registers read 0, `pin_oe`, `pin_out` and `irq` are 0.
- R2: Address 0 holds the direction bits (1 = output), readable, and `pin_oe` equals them one cycle after the write.
- R3: Writing address 1 sets exactly the output bits written as 1; address 1 and address 2 both read back the output register.
- R4: Writing address 2 clears exactly the output bits written as 1 and leaves the other bits unchanged.
- R5: Address 3 reads the sense of each pin: for an output pin, the driven value; for a level-sensitive input pin, the pin value two clocks after it changes.
- R6: Writing address 4 sets mask bits written as 1. Writing address 5 clears mask bits written as 1. Both addresses read the mask.
- R7: A level-sensitive enabled input raises `irq` three clocks after the pin rises and drops it three clocks after the pin falls.
- R8: With its bit set at address 6 (edge) and clear at address 7 (both), an input latches an event on a rising edge, visible at address 3 and on `irq` four clocks after the pin edge. The event persists after the pin falls, and a falling edge alone latches nothing.
- R9: With its bits set at addresses 6 and 7, a falling edge also latches an event.
- R10: Writing a 1 to a pin's bit at address 2 discards its latched event. `irq` drops on the next clock and address 3 reads 0 for that pin.
- R11: For an output pin, software writes drive the request: level mode raises `irq` one clock after the set write, and rising-edge mode two clocks after it.
- R12: `irq` is the OR of enabled requests only. A masked edge event stays latched and raises `irq` one clock after its mask bit is set.
- R13: Addresses 8 to 15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Registered read data |
| pin_in | input | NPINS | Pin input values (asynchronous) |
| pin_out | output | NPINS | Pin output values |
| pin_oe | output | NPINS | Pin output enables |
| irq | output | 1 | Registered interrupt request |

## Verification
Each result has a fixed delay after its stimulus:

| Result | Due after the stimulus |
|---|---|
| Register write visible on the pins or in the mask | 1 edge |
| Read data | 1 edge |
| Level input on `irq` | 3 edges (two synchroniser flops plus the request register) |
| Edge input on `irq` | 4 edges (one more for the event latch) |
| Output-pin request on `irq` | 1 or 2 edges after the set write (level or rising edge) |

The bench changes stimulus on falling edges and counts falling edges to the cycle where each result is due. Where a delay is exact, it checks the cycle before as well as the due cycle.

// File: rtl/gpio_flag_pkg.sv
package gpio_flag_pkg;
  localparam int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RA_DIR   = 4'd0,
    RA_OSET  = 4'd1,
    RA_OCLR  = 4'd2,
    RA_SENSE = 4'd3,
    RA_MSET  = 4'd4,
    RA_MCLR  = 4'd5,
    RA_EDGE  = 4'd6,
    RA_BOTH  = 4'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= '0;
          else        stg_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_flag_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  sense,
  output logic [NPINS-1:0]  rdata,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  mask_q,
  output logic [NPINS-1:0]  edge_q,
  output logic [NPINS-1:0]  both_q,
  output logic [NPINS-1:0]  clr_pulse
);
  logic [NPINS-1:0] dir_d, out_d, mask_d, edge_d, both_d, rd_d, rdata_q;

  always_comb begin
    dir_d  = dir_q;
    out_d  = out_q;
    mask_d = mask_q;
    edge_d = edge_q;
    both_d = both_q;
    if (wr_en) begin
      case (addr)
        RA_DIR:  dir_d  = wdata;
        RA_OSET: out_d  = out_q | wdata;
        RA_OCLR: out_d  = out_q & ~wdata;
        RA_MSET: mask_d = mask_q | wdata;
        RA_MCLR: mask_d = mask_q & ~wdata;
        RA_EDGE: edge_d = wdata;
        RA_BOTH: both_d = wdata;
        default: ;
      endcase
    end
  end

  assign clr_pulse = (wr_en && addr == RA_OCLR) ? wdata : '0;

  always_comb begin
    case (addr)
      RA_DIR:           rd_d = dir_q;
      RA_OSET, RA_OCLR: rd_d = out_q;
      RA_SENSE:         rd_d = sense;
      RA_MSET, RA_MCLR: rd_d = mask_q;
      RA_EDGE:          rd_d = edge_q;
      RA_BOTH:          rd_d = both_q;
      default:          rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      mask_q <= '0;
      edge_q <= '0;
      both_q <= '0;
    end else if (wr_en) begin
      dir_q  <= dir_d;
      out_q  <= out_d;
      mask_q <= mask_d;
      edge_q <= edge_d;
      both_q <= both_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_sync,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] out_q,
  input  logic [NPINS-1:0] mask_q,
  input  logic [NPINS-1:0] edge_q,
  input  logic [NPINS-1:0] both_q,
  input  logic [NPINS-1:0] clr_pulse,
  output logic [NPINS-1:0] sense,
  output logic             irq
);
  logic [NPINS-1:0] src, prev_q, hit, evt_d, evt_q, req;
  logic             irq_d, irq_q;

  // request source: driven value for outputs, synchronised pin for inputs
  assign src = (dir_q & out_q) | (~dir_q & pin_sync);

  always_comb begin
    hit   = ((src & ~prev_q) | (~src & prev_q & both_q)) & edge_q;
    evt_d = ((evt_q & ~clr_pulse) | hit) & edge_q;
    req   = (edge_q & evt_q) | (~edge_q & src);
    irq_d = |(req & mask_q);
  end

  assign sense = (dir_q & out_q)
               | (~dir_q & edge_q & evt_q)
               | (~dir_q & ~edge_q & pin_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= src;
      evt_q  <= evt_d;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank
  import gpio_flag_pkg::*;
#(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] pin_sync, sense;
  logic [NPINS-1:0] dir_q, out_q, mask_q, edge_q, both_q, clr_pulse;
  logic             wr_en, rd_en;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_regs #(.NPINS(NPINS)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .sense     (sense),
    .rdata     (bus_rdata),
    .dir_q     (dir_q),
    .out_q     (out_q),
    .mask_q    (mask_q),
    .edge_q    (edge_q),
    .both_q    (both_q),
    .clr_pulse (clr_pulse)
  );

  gpio_irq #(.NPINS(NPINS)) i_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_sync  (pin_sync),
    .dir_q     (dir_q),
    .out_q     (out_q),
    .mask_q    (mask_q),
    .edge_q    (edge_q),
    .both_q    (both_q),
    .clr_pulse (clr_pulse),
    .sense     (sense),
    .irq       (irq)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_flag_bank_chk.sv
module gpio_flag_bank_chk
  import gpio_flag_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  mask_q,
  input logic              irq
);
  logic wr_dir, wr_set, wr_clr;
  assign wr_dir = bus_sel && bus_wr && bus_addr == RA_DIR;
  assign wr_set = bus_sel && bus_wr && bus_addr == RA_OSET;
  assign wr_clr = bus_sel && bus_wr && bus_addr == RA_OCLR;

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == $past(bus_wdata));

  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

  p_out_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(pin_out));

  p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

  p_masked_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq);
endmodule

bind gpio_flag_bank gpio_flag_bank_chk #(.NPINS(NPINS)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .mask_q    (mask_q),
  .irq       (irq)
);

// File: tb/test_gpio_flag_bank.sv
`timescale 1ns/1ps
module test_gpio_flag_bank;
  localparam int NP = 16;

  typedef struct packed {
    logic        wr;
    logic [3:0]  addr;
    logic [15:0] data;
    logic [15:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd0, 16'hA5A5, 16'h0000, 4'd2},  // R2
    '{1'b0, 4'd0, 16'h0000, 16'hA5A5, 4'd2},  // R2
    '{1'b1, 4'd1, 16'h00F0, 16'h0000, 4'd3},  // R3
    '{1'b0, 4'd1, 16'h0000, 16'h00F0, 4'd3},  // R3
    '{1'b1, 4'd1, 16'h0F00, 16'h0000, 4'd3},  // R3
    '{1'b0, 4'd2, 16'h0000, 16'h0FF0, 4'd3},  // R3
    '{1'b1, 4'd2, 16'h0030, 16'h0000, 4'd4},  // R4
    '{1'b0, 4'd1, 16'h0000, 16'h0FC0, 4'd4},  // R4
    '{1'b1, 4'd4, 16'h1111, 16'h0000, 4'd6},  // R6
    '{1'b1, 4'd4, 16'h0110, 16'h0000, 4'd6},  // R6
    '{1'b0, 4'd4, 16'h0000, 16'h1111, 4'd6},  // R6
    '{1'b1, 4'd5, 16'h1001, 16'h0000, 4'd6},  // R6
    '{1'b0, 4'd5, 16'h0000, 16'h0110, 4'd6},  // R6
    '{1'b1, 4'd6, 16'h3C3C, 16'h0000, 4'd8},  // R8
    '{1'b0, 4'd6, 16'h0000, 16'h3C3C, 4'd8},  // R8
    '{1'b1, 4'd7, 16'h00FF, 16'h0000, 4'd9},  // R9
    '{1'b0, 4'd7, 16'h0000, 16'h00FF, 4'd9},  // R9
    '{1'b1, 4'd9, 16'hFFFF, 16'h0000, 4'd13}, // R13
    '{1'b0, 4'd9, 16'h0000, 16'h0000, 4'd13}, // R13
    '{1'b0, 4'd0, 16'h0000, 16'hA5A5, 4'd13}, // R13
    '{1'b1, 4'd0, 16'h0000, 16'h0000, 4'd2},  // restore
    '{1'b1, 4'd2, 16'hFFFF, 16'h0000, 4'd4},  // restore
    '{1'b1, 4'd5, 16'hFFFF, 16'h0000, 4'd6},  // restore
    '{1'b1, 4'd6, 16'h0000, 16'h0000, 4'd8},  // restore
    '{1'b1, 4'd7, 16'h0000, 16'h0000, 4'd9}   // restore
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic [NP-1:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;
  int            checks = 0;
  int            fails = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_flag_bank #(.NPINS(NP)) i_gpio_flag_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [NP-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [NP-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [NP-1:0] r;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'h0);
    chk("R1 pin_oe", pin_oe, 16'h0);
    chk("R1 pin_out", pin_out, 16'h0);
    rd(4'd0, r); chk("R1 dir", r, 16'h0);
    rd(4'd4, r); chk("R1 mask", r, 16'h0);
    rd(4'd6, r); chk("R1 edge", r, 16'h0);
    rd(4'd7, r); chk("R1 both", r, 16'h0);

    // register access table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        wr(VEC[i].addr, VEC[i].data);
        if (VEC[i].addr == 4'd0) chk($sformatf("R%0d oe", VEC[i].req), pin_oe, VEC[i].data);
      end else begin
        rd(VEC[i].addr, r);
        chk($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].expv);
      end
    end

    // R5 sense: outputs low byte, inputs high byte
    wr(4'd0, 16'h00FF);
    wr(4'd1, 16'h000F);
    pin_in = 16'hA5F0;
    wait_n(3);
    rd(4'd3, r); chk("R5 sense", r, 16'hA50F);
    pin_in = '0;
    wr(4'd2, 16'hFFFF);
    wr(4'd0, 16'h0000);
    wait_n(3);

    // R7 level input latency
    wr(4'd4, 16'h0001);
    pin_in[0] = 1'b1;
    wait_n(2); chk("R7 rise early", {15'd0, irq}, 16'h0);
    wait_n(1); chk("R7 rise due", {15'd0, irq}, 16'h1);
    pin_in[0] = 1'b0;
    wait_n(2); chk("R7 fall early", {15'd0, irq}, 16'h1);
    wait_n(1); chk("R7 fall due", {15'd0, irq}, 16'h0);
    // R12 masked level pin
    pin_in[1] = 1'b1;
    wait_n(5); chk("R12 masked level", {15'd0, irq}, 16'h0);
    pin_in[1] = 1'b0;
    wr(4'd5, 16'h0001);
    wait_n(3);

    // R8 rising edge latch
    wr(4'd6, 16'h0004);
    wr(4'd4, 16'h0004);
    pin_in[2] = 1'b1;
    wait_n(3); chk("R8 edge early", {15'd0, irq}, 16'h0);
    wait_n(1); chk("R8 edge due", {15'd0, irq}, 16'h1);
    pin_in[2] = 1'b0;
    wait_n(4); chk("R8 held", {15'd0, irq}, 16'h1);
    rd(4'd3, r); chk("R8 sense latched", r, 16'h0004);
    // R10 clear event
    wr(4'd2, 16'h0004);
    wait_n(1); chk("R10 irq cleared", {15'd0, irq}, 16'h0);
    rd(4'd3, r); chk("R10 sense cleared", r, 16'h0000);
    // R8 falling edge alone ignored
    pin_in[2] = 1'b1;
    wait_n(5);
    wr(4'd2, 16'h0004);
    pin_in[2] = 1'b0;
    wait_n(5); chk("R8 fall ignored", {15'd0, irq}, 16'h0);
    rd(4'd3, r); chk("R8 fall sense", r, 16'h0000);

    // R9 both edges
    wr(4'd7, 16'h0004);
    pin_in[2] = 1'b1;
    wait_n(5);
    wr(4'd2, 16'h0004);
    wait_n(1); chk("R9 cleared", {15'd0, irq}, 16'h0);
    pin_in[2] = 1'b0;
    wait_n(3); chk("R9 fall early", {15'd0, irq}, 16'h0);
    wait_n(1); chk("R9 fall due", {15'd0, irq}, 16'h1);
    wr(4'd2, 16'h0004);
    wr(4'd7, 16'h0000);

    // R12 masked event stays latched
    wr(4'd5, 16'h0004);
    pin_in[2] = 1'b1;
    wait_n(5); chk("R12 masked edge", {15'd0, irq}, 16'h0);
    rd(4'd3, r); chk("R12 latched", r, 16'h0004);
    wr(4'd4, 16'h0004);
    wait_n(1); chk("R12 unmask", {15'd0, irq}, 16'h1);
    wr(4'd5, 16'hFFFF);
    wr(4'd2, 16'hFFFF);
    wr(4'd6, 16'h0000);
    pin_in = '0;
    wait_n(4);

    // R11 output pin requests
    wr(4'd0, 16'h0100);
    wr(4'd4, 16'h0100);
    wait_n(1); chk("R11 idle", {15'd0, irq}, 16'h0);
    wr(4'd1, 16'h0100);
    wait_n(1); chk("R11 level set", {15'd0, irq}, 16'h1);
    wr(4'd2, 16'h0100);
    wait_n(1); chk("R11 level clear", {15'd0, irq}, 16'h0);
    wr(4'd6, 16'h0100);
    wr(4'd1, 16'h0100);
    wait_n(1); chk("R11 edge early", {15'd0, irq}, 16'h0);
    wait_n(1); chk("R11 edge due", {15'd0, irq}, 16'h1);
    wr(4'd2, 16'h0100);
    wait_n(1); chk("R11 edge cleared", {15'd0, irq}, 16'h0);
    chk("R4 pin_out after clear", pin_out, 16'h0000);

    done = 1'b1;
    finish_run();
  end
endmodule